// File: doc/BRIEF.md
# PWM Output Compare Channel

This block is one output-compare channel of a general-purpose timer. A separate time-base unit supplies the running count, the counting direction, the auto-reload limit, the update-event strobe and the center-aligned setting. The channel compares the count with its active compare value and produces a PWM reference level, an output pin level after polarity and enable, and a sticky compare flag that software clears.

The compare value can be written straight into the active register, or into a preload buffer that moves to the active register only on an update event. Two small state machines hold the sequencing. The flag machine has the states `FLAG_IDLE` and `FLAG_RAISED`. Its transitions are `HIT` (IDLE to RAISED on a gated compare match), `CLEAR` (RAISED to IDLE on a software clear with no match in that cycle) and `HOLD` (RAISED stays RAISED). The range tracker has the states `RANGE_NORMAL` and `RANGE_OVER`. On every update event it moves to `RANGE_OVER` if the period that is ending had an active compare value at or above the auto-reload value. Otherwise it moves to `RANGE_NORMAL`. While it is in `RANGE_OVER` with an active value of 0, the count of 0 produces no compare event and a low mode-1 reference.

Top module: `pwm_oc_channel`

## Requirements
- R1: With mode code 3'b110 (PWM mode 1) and the count going up (`cnt_down_i`=0), `oc_ref_o` is 1 when count < active compare value and 0 otherwise.
- R2: With mode code 3'b110 and the count going down (`cnt_down_i`=1), `oc_ref_o` is 0 when count > active compare value and 1 otherwise.
- R3: Mode code 3'b111 (PWM mode 2) gives the inverse of the mode-1 reference. Every other mode code holds `oc_ref_o` at 0.
- R4: In mode 1, an active compare value greater than `arr_i` keeps the reference at 1 in both directions. An active value of 0 keeps it at 0 while counting up.
- R5: With `preload_en_i`=1, a write changes only the preload buffer, and the buffer is copied to the active value on the edge where `update_i`=1. A write in the same cycle as `update_i` goes straight to the active value.
- R6: With `preload_en_i`=0, a write changes the active value on the clock edge of the write.
- R7: `cmp_flag_o` is set one edge after a cycle in which count equals the active value, subject to direction gating by `center_sel_i`. The encodings are: 2'b00 sets in either direction, 2'b01 only when counting down, 2'b10 only when counting up, and 2'b11 in either direction.
- R8: `cmp_flag_o` stays set until `flag_clr_i`. When a clear and a gated match fall in the same cycle, the flag stays set.
- R9: After an update event that ends a period whose active value was >= `arr_i`, if the new active value is 0, then a count of 0 sets no flag and gives a mode-1 reference of 0 in both directions.
- R10: `oc_o` equals `oc_ref_o` XOR `polarity_i` when `chan_en_i`=1, and equals `polarity_i` when `chan_en_i`=0.
- R11: Reset clears the active value, the preload buffer and the flag, and puts the range tracker in `RANGE_NORMAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Count from the time base |
| cnt_down_i | input | 1 | 1 when the time base counts down |
| arr_i | input | CNT_W | Auto-reload value of the time base |
| update_i | input | 1 | Update-event strobe, one cycle |
| center_sel_i | input | 2 | Center-aligned setting (flag direction gating) |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value to write |
| oc_mode_i | input | 3 | Output mode code |
| preload_en_i | input | 1 | Enables the preload buffer |
| polarity_i | input | 1 | Output polarity (1 inverts) |
| chan_en_i | input | 1 | Channel output enable |
| flag_clr_i | input | 1 | Software clear of the compare flag |
| oc_ref_o | output | 1 | PWM reference level |
| oc_o | output | 1 | Output pin level |
| cmp_flag_o | output | 1 | Sticky compare flag |

## Verification
The flag machine can take a gated compare match and a software clear in the same cycle. The bench provokes this by holding the count equal to the active value while it pulses `flag_clr_i`. It then checks that the flag is still set after that edge, and that it drops on the next clear, which comes with the count moved away. In the same way, an update event and a compare write are placed in one cycle. The bench judges the result from the reference level that the new active value must produce.

// File: rtl/pwm_oc_pkg.sv
package pwm_oc_pkg;

    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

    typedef enum logic {
        RANGE_NORMAL = 1'b0,
        RANGE_OVER   = 1'b1
    } range_state_e;

    localparam logic [2:0] MODE_PWM1 = 3'b110;
    localparam logic [2:0] MODE_PWM2 = 3'b111;

    localparam logic [1:0] CSEL_EDGE = 2'b00;
    localparam logic [1:0] CSEL_DOWN = 2'b01;
    localparam logic [1:0] CSEL_UP   = 2'b10;
    localparam logic [1:0] CSEL_BOTH = 2'b11;

endpackage

// File: rtl/pwm_oc_ccr_reg.sv
module pwm_oc_ccr_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             preload_en_i,
    input  logic             update_i,
    output logic [CNT_W-1:0] active_o
);
    logic [CNT_W-1:0] buf_q;
    logic [CNT_W-1:0] act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (wr_i) begin
                buf_q <= wdata_i;
            end
            if (wr_i && (!preload_en_i || update_i)) begin
                act_q <= wdata_i;
            end else if (preload_en_i && update_i) begin
                act_q <= buf_q;
            end
        end
    end

    assign active_o = act_q;
endmodule

// File: rtl/pwm_oc_range_fsm.sv
module pwm_oc_range_fsm
    import pwm_oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             update_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] arr_i,
    input  logic [CNT_W-1:0] active_i,
    output logic             zero_mask_o
);
    range_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (update_i) begin
            state_d = (active_i >= arr_i) ? RANGE_OVER : RANGE_NORMAL;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RANGE_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        zero_mask_o = 1'b0;
        unique case (state_q)
            RANGE_NORMAL: zero_mask_o = 1'b0;
            RANGE_OVER:   zero_mask_o = (active_i == '0) && (cnt_i == '0);
            default:      zero_mask_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_oc_flag_fsm.sv
module pwm_oc_flag_fsm
    import pwm_oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_down_i,
    input  logic [1:0]       center_sel_i,
    input  logic [CNT_W-1:0] active_i,
    input  logic             zero_mask_i,
    input  logic             clr_i,
    output logic             flag_o
);
    flag_state_e state_q, state_d;
    logic        dir_ok;
    logic        hit;

    always_comb begin
        unique case (center_sel_i)
            CSEL_EDGE: dir_ok = 1'b1;
            CSEL_DOWN: dir_ok = cnt_down_i;
            CSEL_UP:   dir_ok = !cnt_down_i;
            CSEL_BOTH: dir_ok = 1'b1;
            default:   dir_ok = 1'b1;
        endcase
    end

    assign hit = (cnt_i == active_i) && dir_ok && !zero_mask_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (hit) state_d = FLAG_RAISED;
            FLAG_RAISED: if (clr_i && !hit) state_d = FLAG_IDLE;
            default:     state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            FLAG_IDLE:   flag_o = 1'b0;
            FLAG_RAISED: flag_o = 1'b1;
            default:     flag_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_oc_ref_gen.sv
module pwm_oc_ref_gen
    import pwm_oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_down_i,
    input  logic [CNT_W-1:0] arr_i,
    input  logic [CNT_W-1:0] active_i,
    input  logic [2:0]       mode_i,
    input  logic             zero_mask_i,
    output logic             ref_o
);
    logic lvl1;

    always_comb begin
        if (zero_mask_i) begin
            lvl1 = 1'b0;
        end else if (active_i > arr_i) begin
            lvl1 = 1'b1;
        end else if (cnt_down_i) begin
            lvl1 = (cnt_i <= active_i);
        end else begin
            lvl1 = (cnt_i < active_i);
        end
    end

    always_comb begin
        case (mode_i)
            MODE_PWM1: ref_o = lvl1;
            MODE_PWM2: ref_o = !lvl1;
            default:   ref_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_oc_channel.sv
module pwm_oc_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_down_i,
    input  logic [CNT_W-1:0] arr_i,
    input  logic             update_i,
    input  logic [1:0]       center_sel_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    input  logic [2:0]       oc_mode_i,
    input  logic             preload_en_i,
    input  logic             polarity_i,
    input  logic             chan_en_i,
    input  logic             flag_clr_i,
    output logic             oc_ref_o,
    output logic             oc_o,
    output logic             cmp_flag_o
);
    logic [CNT_W-1:0] ccr_act;
    logic             zero_mask;

    pwm_oc_ccr_reg #(.CNT_W(CNT_W)) u_ccr (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_i         (cmp_wr_i),
        .wdata_i      (cmp_wdata_i),
        .preload_en_i (preload_en_i),
        .update_i     (update_i),
        .active_o     (ccr_act)
    );

    pwm_oc_range_fsm #(.CNT_W(CNT_W)) u_range (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .update_i    (update_i),
        .cnt_i       (cnt_i),
        .arr_i       (arr_i),
        .active_i    (ccr_act),
        .zero_mask_o (zero_mask)
    );

    pwm_oc_ref_gen #(.CNT_W(CNT_W)) u_ref (
        .cnt_i       (cnt_i),
        .cnt_down_i  (cnt_down_i),
        .arr_i       (arr_i),
        .active_i    (ccr_act),
        .mode_i      (oc_mode_i),
        .zero_mask_i (zero_mask),
        .ref_o       (oc_ref_o)
    );

    pwm_oc_flag_fsm #(.CNT_W(CNT_W)) u_flag (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cnt_i        (cnt_i),
        .cnt_down_i   (cnt_down_i),
        .center_sel_i (center_sel_i),
        .active_i     (ccr_act),
        .zero_mask_i  (zero_mask),
        .clr_i        (flag_clr_i),
        .flag_o       (cmp_flag_o)
    );

    assign oc_o = chan_en_i ? (oc_ref_o ^ polarity_i) : polarity_i;
endmodule

// File: rtl/pwm_oc_channel_chk.sv
module pwm_oc_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CNT_W-1:0] cnt_i,
    input logic             cnt_down_i,
    input logic [CNT_W-1:0] arr_i,
    input logic             update_i,
    input logic [1:0]       center_sel_i,
    input logic             cmp_wr_i,
    input logic             preload_en_i,
    input logic [2:0]       oc_mode_i,
    input logic             polarity_i,
    input logic             chan_en_i,
    input logic             flag_clr_i,
    input logic             oc_ref_o,
    input logic             oc_o,
    input logic             cmp_flag_o,
    input logic [CNT_W-1:0] ccr_act,
    input logic             zero_mask
);
    p_disabled_pin_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !chan_en_i |-> (oc_o == polarity_i));

    p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_flag_o && !flag_clr_i) |=> cmp_flag_o);

    p_edge_match_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (center_sel_i == 2'b00 && cnt_i == ccr_act && !zero_mask) |=> cmp_flag_o);

    p_down_only_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (center_sel_i == 2'b01 && !cnt_down_i && !cmp_flag_o) |=> !cmp_flag_o);

    p_over_range_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oc_mode_i == 3'b110 && ccr_act > arr_i) |-> oc_ref_o);

    p_preload_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (preload_en_i && !update_i) |=> $stable(ccr_act));

    p_zero_mask_no_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (zero_mask && !cmp_flag_o) |=> !cmp_flag_o);
endmodule

bind pwm_oc_channel pwm_oc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnt_i        (cnt_i),
    .cnt_down_i   (cnt_down_i),
    .arr_i        (arr_i),
    .update_i     (update_i),
    .center_sel_i (center_sel_i),
    .cmp_wr_i     (cmp_wr_i),
    .preload_en_i (preload_en_i),
    .oc_mode_i    (oc_mode_i),
    .polarity_i   (polarity_i),
    .chan_en_i    (chan_en_i),
    .flag_clr_i   (flag_clr_i),
    .oc_ref_o     (oc_ref_o),
    .oc_o         (oc_o),
    .cmp_flag_o   (cmp_flag_o),
    .ccr_act      (ccr_act),
    .zero_mask    (zero_mask)
);

// File: tb/pwm_oc_channel_tb.sv
module pwm_oc_channel_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt = '0;
    logic         dn = 1'b0;
    logic [W-1:0] arr = 16'd8;
    logic         upd = 1'b0;
    logic [1:0]   csel = 2'b00;
    logic         wr = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [2:0]   mode = 3'b110;
    logic         pre = 1'b0;
    logic         pol = 1'b0;
    logic         en = 1'b1;
    logic         clr = 1'b0;
    logic         ref_o, oc, flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_oc_channel #(.CNT_W(W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_down_i(dn), .arr_i(arr),
        .update_i(upd), .center_sel_i(csel), .cmp_wr_i(wr), .cmp_wdata_i(wdata),
        .oc_mode_i(mode), .preload_en_i(pre), .polarity_i(pol), .chan_en_i(en),
        .flag_clr_i(clr), .oc_ref_o(ref_o), .oc_o(oc), .cmp_flag_o(flag)
    );

    typedef struct packed {
        logic [15:0] c;
        logic        d;
        logic [15:0] k;
        logic [2:0]  m;
        logic        p;
        logic        e;
        logic        xr;
        logic        xo;
    } vec_t;

    localparam vec_t VEC [14] = '{
        '{16'd3, 1'b0, 16'd5, 3'b110, 1'b0, 1'b1, 1'b1, 1'b1}, // R1
        '{16'd5, 1'b0, 16'd5, 3'b110, 1'b0, 1'b1, 1'b0, 1'b0}, // R1
        '{16'd7, 1'b0, 16'd5, 3'b110, 1'b1, 1'b1, 1'b0, 1'b1}, // R1 R10
        '{16'd5, 1'b1, 16'd5, 3'b110, 1'b0, 1'b1, 1'b1, 1'b1}, // R2
        '{16'd6, 1'b1, 16'd5, 3'b110, 1'b0, 1'b1, 1'b0, 1'b0}, // R2
        '{16'd3, 1'b0, 16'd5, 3'b111, 1'b0, 1'b1, 1'b0, 1'b0}, // R3
        '{16'd6, 1'b1, 16'd5, 3'b111, 1'b0, 1'b1, 1'b1, 1'b1}, // R3
        '{16'd3, 1'b0, 16'd5, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0}, // R3
        '{16'd8, 1'b0, 16'd9, 3'b110, 1'b0, 1'b1, 1'b1, 1'b1}, // R4
        '{16'd8, 1'b1, 16'd9, 3'b110, 1'b0, 1'b1, 1'b1, 1'b1}, // R4
        '{16'd0, 1'b0, 16'd0, 3'b110, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
        '{16'd2, 1'b0, 16'd5, 3'b110, 1'b1, 1'b0, 1'b1, 1'b1}, // R10
        '{16'd2, 1'b0, 16'd5, 3'b110, 1'b0, 1'b0, 1'b1, 1'b0}, // R10
        '{16'd4, 1'b0, 16'd5, 3'b110, 1'b1, 1'b1, 1'b1, 1'b0}  // R10
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic write_ccr(input logic [W-1:0] v, input logic with_upd);
        @(negedge clk);
        wr = 1'b1; wdata = v; upd = with_upd;
        @(negedge clk);
        wr = 1'b0; upd = 1'b0;
    endtask

    task automatic pulse_upd();
        @(negedge clk);
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    task automatic step(input logic [W-1:0] c, input logic d, input logic [1:0] cs, input logic cl);
        @(negedge clk);
        cnt = c; dn = d; csel = cs; clr = cl;
        @(posedge clk);
        #2;
        clr = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: reset state, count 3 with active value 0
        cnt = 16'd3;
        #2;
        chk("R11 flag in reset", flag, 1'b0);
        chk("R11 ref with cleared active value", ref_o, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R11 flag after reset", flag, 1'b0);

        // table walk, preload off
        for (int i = 0; i < 14; i++) begin
            pre = 1'b0;
            write_ccr(VEC[i].k, 1'b0);
            cnt = VEC[i].c; dn = VEC[i].d; mode = VEC[i].m;
            pol = VEC[i].p; en = VEC[i].e;
            #2;
            chk($sformatf("R1-table ref vec %0d", i), ref_o, VEC[i].xr);
            chk($sformatf("R10 oc vec %0d", i), oc, VEC[i].xo);
        end

        // R5 preload
        mode = 3'b110; pol = 1'b0; en = 1'b1; dn = 1'b0; cnt = 16'd4;
        write_ccr(16'd5, 1'b0);
        pre = 1'b1;
        write_ccr(16'd2, 1'b0);
        #2; chk("R5 buffered write not active", ref_o, 1'b1);
        pulse_upd();
        #2; chk("R5 copied on update", ref_o, 1'b0);
        write_ccr(16'd7, 1'b1);
        #2; chk("R5 write during update", ref_o, 1'b1);

        // R6 immediate
        pre = 1'b0;
        write_ccr(16'd3, 1'b0);
        #2; chk("R6 immediate write", ref_o, 1'b0);

        // R7 direction gating, active value 3
        step(16'd1, 1'b0, 2'b00, 1'b1);
        chk("R7 cleared", flag, 1'b0);
        step(16'd3, 1'b0, 2'b01, 1'b0);
        chk("R7 down-only ignores up", flag, 1'b0);
        step(16'd3, 1'b1, 2'b01, 1'b0);
        chk("R7 down-only sets on down", flag, 1'b1);
        step(16'd1, 1'b0, 2'b00, 1'b1);
        step(16'd3, 1'b1, 2'b10, 1'b0);
        chk("R7 up-only ignores down", flag, 1'b0);
        step(16'd3, 1'b0, 2'b10, 1'b0);
        chk("R7 up-only sets on up", flag, 1'b1);
        step(16'd1, 1'b0, 2'b00, 1'b1);
        step(16'd3, 1'b1, 2'b11, 1'b0);
        chk("R7 both sets on down", flag, 1'b1);
        step(16'd1, 1'b0, 2'b00, 1'b1);
        step(16'd3, 1'b0, 2'b00, 1'b0);
        chk("R7 edge sets on up", flag, 1'b1);

        // R8 sticky and set-beats-clear
        step(16'd5, 1'b0, 2'b00, 1'b0);
        step(16'd6, 1'b0, 2'b00, 1'b0);
        chk("R8 sticky", flag, 1'b1);
        step(16'd3, 1'b0, 2'b00, 1'b1);
        chk("R8 match beats clear", flag, 1'b1);
        step(16'd5, 1'b0, 2'b00, 1'b1);
        chk("R8 clear", flag, 1'b0);

        // R9 zero after over-range period
        pre = 1'b1; cnt = 16'd5;
        write_ccr(16'd9, 1'b1);
        write_ccr(16'd0, 1'b1);
        step(16'd5, 1'b0, 2'b00, 1'b1);
        chk("R9 cleared before", flag, 1'b0);
        step(16'd0, 1'b0, 2'b00, 1'b0);
        chk("R9 up ref low", ref_o, 1'b0);
        chk("R9 no flag at zero", flag, 1'b0);
        step(16'd0, 1'b1, 2'b00, 1'b0);
        chk("R9 down ref low", ref_o, 1'b0);
        chk("R9 no flag at zero down", flag, 1'b0);
        cnt = 16'd5;
        pulse_upd();
        step(16'd0, 1'b1, 2'b00, 1'b0);
        chk("R9 normal period ref high", ref_o, 1'b1);
        chk("R9 normal period flag", flag, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule